// File: doc/BRIEF.md
# MDIO Station-Management Master

This block is the management-side master of a two-wire station-management bus. It owns the management clock and the bidirectional data line, and it serialises both frame clauses of that bus: the short-address clause-22 form and the clause-45 form, which is indirect and reaches a PHY's manageable devices. Software sees four 32-bit registers behind a one-cycle write strobe and a combinational read port. These are a clock and mode register, a command register, a write-data register and a read-data register.

To make an access, software first places the outgoing 16-bit value in the write-data register. For a clause-45 address cycle this value is the target register address. Software then writes the command. The master latches mode, preamble choice, command and data, and shifts the frame out MSB first. On read operations it lets go of the line from the turnaround onward. When the frame ends it reports the outcome in the pending and valid flags. Software polls the pending flag and applies any timeout policy it wants.

Top module: `mdio_master`

## Requirements
- R1: After reset, MDC is low, the master does not drive MDIO (mdio_oe=0), and both pending flags and the valid flag are 0. The clock/mode register (address 0) reads back with the divider at DIV_RESET in bits [7:0], the clause-45 mode bit (bit 8) at 0 and the preamble-enable bit (bit 9) at 1. With the default parameters this value is 0x204.
- R2: While a frame runs, each MDC half period lasts (divider+1) system clocks, so one full MDC period is 2*(divider+1) clocks. While no frame runs, MDC is held low and does not toggle.
- R3: The master changes mdio_o and mdio_oe only when MDC falls, or in the cycle a frame starts. It samples MDIO on the MDC rising edge.
- R4: A clause-22 frame (mode bit 0) is sent in this order: start 01, wire opcode, 5-bit PHY address, 5-bit register address, turnaround, 16 data bits MSB first. Command op 0 (write) goes out as 01 and sends turnaround 10 followed by write-data[15:0]. Command op 1 (read) goes out as 10. In the command register (address 1) the op is in bits [1:0], the PHY address in [12:8] and the register/device field in [20:16].
- R5: When the preamble-enable bit is 1, each frame starts with 32 ones, giving 64 MDC cycles in total. When the bit is 0, the frame is 32 MDC cycles and starts directly with the start pattern.
- R6: A clause-45 frame (mode bit 1) has start 00 and puts the 2-bit command op on the wire unchanged: 0 address, 1 write, 2 read with post-increment, 3 read. Bits [20:16] carry the device number. Address and write cycles send turnaround 10 and then write-data[15:0].
- R7: On a read, mdio_oe is 0 from the first turnaround bit to the end of the frame. The 16 bits sampled after the turnaround appear MSB first in read-data[15:0] (address 3). The valid flag (read-data bit 30) is set at the end of the frame only if MDIO was 0 in the second turnaround bit. Otherwise it is 0. A new command clears it.
- R8: While a frame is in progress, bit 31 of the write-data register (address 2) and bit 31 of the read-data register both read 1. Both clear when the frame ends.
- R9: A command written while a frame is pending is ignored. The running frame completes unchanged and no further frame follows.
- R10: At the end of every frame the master releases MDIO (mdio_oe=0, mdio_o=1) and MDC stays low until the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 clock/mode, 1 command, 2 write data, 3 read data |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Register read value for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Sensed level of the MDIO line |
| mdio_o | output | 1 | Level driven onto MDIO when enabled |
| mdio_oe | output | 1 | MDIO drive enable |

## Verification
Internal state in this block is almost entirely the shift register, the remaining-bit counter and the divider phase. A wrong value in any of them shows up on the wire within one MDC period. Each frame is therefore compared bit for bit against the MDIO line sampled at each MDC rise, together with the master's drive-enable at the same instant. A miscount of the preamble or of the turnaround position changes the frame length, so the expected and observed frames fall out of step at once, and an unexpected frame appears after a refused command. A fault in the read path is first visible in the read-data register after the frame ends: a wrong valid flag or shifted data bits. Because of that, every read frame is followed by a register read.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
   localparam logic [1:0] ADDR_CLK  = 2'd0;
   localparam logic [1:0] ADDR_CMD  = 2'd1;
   localparam logic [1:0] ADDR_WDAT = 2'd2;
   localparam logic [1:0] ADDR_RDAT = 2'd3;

   localparam int MODE_BIT  = 8;
   localparam int PRE_BIT   = 9;
   localparam int VALID_BIT = 30;
   localparam int PEND_BIT  = 31;

   typedef struct packed {
      logic [1:0] op;
      logic [4:0] phy;
      logic [4:0] dev;
   } mdio_cmd_t;

   function automatic logic op_is_read(input logic c45, input logic [1:0] op);
      return c45 ? op[1] : op[0];
   endfunction

   // 32-bit frame body following the optional preamble, first bit at MSB
   function automatic logic [31:0] frame_body(input logic c45, input mdio_cmd_t cmd,
                                              input logic [15:0] wd);
      logic [1:0] st;
      logic [1:0] wire_op;
      logic [1:0] ta;
      st      = c45 ? 2'b00 : 2'b01;
      wire_op = c45 ? cmd.op : (cmd.op[0] ? 2'b10 : 2'b01);
      ta      = op_is_read(c45, cmd.op) ? 2'b11 : 2'b10;
      return {st, wire_op, cmd.phy, cmd.dev, ta, wd};
   endfunction
endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
module mdio_clkgen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half_div,
   output logic             mdc,
   output logic             rise_tick,
   output logic             fall_tick
);
   logic [DIV_W-1:0] phase_q;
   logic             wrap;

   assign wrap      = run && (phase_q >= half_div);
   assign rise_tick = wrap && !mdc;
   assign fall_tick = wrap && mdc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= '0;
         mdc     <= 1'b0;
      end else if (!run) begin
         phase_q <= '0;
         mdc     <= 1'b0;
      end else if (wrap) begin
         phase_q <= '0;
         mdc     <= ~mdc;
      end else begin
         phase_q <= phase_q + 1'b1;
      end
   end
endmodule

// File: rtl/mdio_seq.sv
`timescale 1ns/1ps
module mdio_seq
   import mdio_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int PRE_BITS    = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        c45,
   input  logic        pre_en,
   input  mdio_cmd_t   cmd,
   input  logic [15:0] wdata,
   input  logic        rise_tick,
   input  logic        fall_tick,
   input  logic        mdio_i,
   output logic        busy,
   output logic        mdio_o,
   output logic        mdio_oe,
   output logic [15:0] rd_data,
   output logic        rd_valid
);
   localparam int FRAME_W = PRE_BITS + 32;
   localparam int REM_W   = $clog2(FRAME_W + 1);
   localparam logic [REM_W-1:0] REM_FULL = REM_W'(FRAME_W);
   localparam logic [REM_W-1:0] REM_BARE = REM_W'(32);
   localparam logic [REM_W-1:0] REM_REL  = REM_W'(19);
   localparam logic [REM_W-1:0] REM_TA2  = REM_W'(17);
   localparam logic [REM_W-1:0] REM_DAT  = REM_W'(16);
   localparam logic [REM_W-1:0] REM_LAST = REM_W'(1);

   logic mdio_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign mdio_s = mdio_i;
      end else if (SYNC_STAGES == 1) begin : g_sync1
         logic s_q;
         always_ff @(posedge clk) begin
            if (!rst_n) s_q <= 1'b1;
            else        s_q <= mdio_i;
         end
         assign mdio_s = s_q;
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0] s_q;
         always_ff @(posedge clk) begin
            if (!rst_n) s_q <= '1;
            else        s_q <= {s_q[SYNC_STAGES-2:0], mdio_i};
         end
         assign mdio_s = s_q[SYNC_STAGES-1];
      end
   endgenerate

   logic [FRAME_W-1:0] shreg_q;
   logic [REM_W-1:0]   rem_q;
   logic               oe_q;
   logic               rd_op_q;
   logic               ta_ok_q;
   logic [31:0]        body;

   assign body    = frame_body(c45, cmd, wdata);
   assign mdio_oe = oe_q;
   assign mdio_o  = oe_q ? shreg_q[FRAME_W-1] : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         shreg_q  <= '0;
         rem_q    <= '0;
         oe_q     <= 1'b0;
         rd_op_q  <= 1'b0;
         ta_ok_q  <= 1'b0;
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else if (start && !busy) begin
         busy     <= 1'b1;
         shreg_q  <= pre_en ? {{PRE_BITS{1'b1}}, body} : {body, {PRE_BITS{1'b0}}};
         rem_q    <= pre_en ? REM_FULL : REM_BARE;
         oe_q     <= 1'b1;
         rd_op_q  <= op_is_read(c45, cmd.op);
         ta_ok_q  <= 1'b0;
         rd_valid <= 1'b0;
      end else if (busy) begin
         if (rise_tick && rd_op_q) begin
            if (rem_q == REM_TA2) ta_ok_q <= !mdio_s;
            if (rem_q <= REM_DAT) rd_data <= {rd_data[14:0], mdio_s};
         end
         if (fall_tick) begin
            if (rem_q == REM_LAST) begin
               busy     <= 1'b0;
               oe_q     <= 1'b0;
               rd_valid <= rd_op_q && ta_ok_q;
            end else begin
               shreg_q <= shreg_q << 1;
               rem_q   <= rem_q - 1'b1;
               oe_q    <= !(rd_op_q && (rem_q <= REM_REL));
            end
         end
      end
   end
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
   import mdio_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int DIV_RESET   = 4,
   parameter int SYNC_STAGES = 2,
   parameter int PRE_BITS    = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [1:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        mdc,
   input  logic        mdio_i,
   output logic        mdio_o,
   output logic        mdio_oe
);
   generate
      if (DIV_W < 1 || DIV_W > MODE_BIT) begin : g_bad_div
         $error("DIV_W must lie in 1..8");
      end
      if (DIV_RESET < 0 || DIV_RESET >= (1 << DIV_W)) begin : g_bad_rst
         $error("DIV_RESET does not fit DIV_W");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
      if (PRE_BITS < 1) begin : g_bad_pre
         $error("PRE_BITS must be positive");
      end
   endgenerate

   logic [DIV_W-1:0] div_q;
   logic             c45_q;
   logic             pre_q;
   logic [15:0]      wdat_q;
   mdio_cmd_t        cmd_q;
   mdio_cmd_t        cmd_in;
   logic             busy;
   logic             start;
   logic             rise_tick;
   logic             fall_tick;
   logic [15:0]      rd_data;
   logic             rd_valid;
   logic             unused_bits;

   assign unused_bits = ^reg_wdata[31:21];
   assign cmd_in = '{op: reg_wdata[1:0], phy: reg_wdata[12:8], dev: reg_wdata[20:16]};
   assign start  = reg_we && (reg_addr == ADDR_CMD) && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q  <= DIV_W'(DIV_RESET);
         c45_q  <= 1'b0;
         pre_q  <= 1'b1;
         wdat_q <= '0;
         cmd_q  <= '0;
      end else if (reg_we) begin
         case (reg_addr)
            ADDR_CLK: begin
               div_q <= reg_wdata[DIV_W-1:0];
               c45_q <= reg_wdata[MODE_BIT];
               pre_q <= reg_wdata[PRE_BIT];
            end
            ADDR_CMD:  if (!busy) cmd_q <= cmd_in;
            ADDR_WDAT: wdat_q <= reg_wdata[15:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_CLK: begin
            reg_rdata[DIV_W-1:0] = div_q;
            reg_rdata[MODE_BIT]  = c45_q;
            reg_rdata[PRE_BIT]   = pre_q;
         end
         ADDR_CMD: begin
            reg_rdata[1:0]   = cmd_q.op;
            reg_rdata[12:8]  = cmd_q.phy;
            reg_rdata[20:16] = cmd_q.dev;
         end
         ADDR_WDAT: begin
            reg_rdata[15:0]     = wdat_q;
            reg_rdata[PEND_BIT] = busy;
         end
         default: begin
            reg_rdata[15:0]      = rd_data;
            reg_rdata[VALID_BIT] = rd_valid;
            reg_rdata[PEND_BIT]  = busy;
         end
      endcase
   end

   mdio_clkgen #(.DIV_W(DIV_W)) i_clkgen (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (busy),
      .half_div  (div_q),
      .mdc       (mdc),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick)
   );

   mdio_seq #(.SYNC_STAGES(SYNC_STAGES), .PRE_BITS(PRE_BITS)) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .c45       (c45_q),
      .pre_en    (pre_q),
      .cmd       (cmd_in),
      .wdata     (wdat_q),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick),
      .mdio_i    (mdio_i),
      .busy      (busy),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe),
      .rd_data   (rd_data),
      .rd_valid  (rd_valid)
   );
endmodule

// File: rtl/mdio_master_chk.sv
`timescale 1ns/1ps
module mdio_master_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       mdc,
   input logic       mdio_o,
   input logic       mdio_oe,
   input logic       busy,
   input logic       rd_valid,
   input logic       reg_we,
   input logic [1:0] reg_addr
);
   p_mdc_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc);

   p_hold_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

   p_valid_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_valid) |-> $fell(busy));

   p_start_from_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(reg_we && (reg_addr == 2'd1)));

   p_release_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (!mdio_oe && mdio_o));
endmodule

bind mdio_master mdio_master_chk i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mdc      (mdc),
   .mdio_o   (mdio_o),
   .mdio_oe  (mdio_oe),
   .busy     (busy),
   .rd_valid (rd_valid),
   .reg_we   (reg_we),
   .reg_addr (reg_addr)
);

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
   import mdio_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        phy_oe = 1'b0;
   logic        phy_o = 1'b1;
   logic        bus_line;

   assign bus_line = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

   always #2.5 clk = ~clk;

   mdio_master i_mdio_master (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
      .mdio_i(bus_line), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   typedef struct {
      int          len;
      logic [63:0] bits;
      logic [63:0] oe;
      string       req;
   } frame_t;

   frame_t      exp_q[$];
   int          rise_cnt = 0;
   int          frames_seen = 0;
   int          frames_sent = 0;
   logic [63:0] got_b = '0;
   logic [63:0] got_oe = '0;
   int          phy_len = 0;
   bit          phy_read = 1'b0;
   logic [16:0] phy_resp = '0;

   // scoreboard monitor: collect line and drive-enable at each MDC rise
   always @(posedge mdc) begin : mon
      frame_t      f;
      logic [63:0] mask;
      got_b  = {got_b[62:0], bus_line};
      got_oe = {got_oe[62:0], mdio_oe};
      rise_cnt++;
      if (exp_q.size() == 0) begin
         if (rise_cnt == 1) check(1'b0, "R9 unexpected frame", 64'(rise_cnt), 64'd0);
      end else if (rise_cnt == exp_q[0].len) begin
         f = exp_q.pop_front();
         mask = (f.len == 64) ? '1 : ((64'd1 << f.len) - 64'd1);
         check((got_b & mask) == (f.bits & mask), f.req, got_b & mask, f.bits & mask);
         check((got_oe & mask) == (f.oe & mask), {f.req, " R7 drive"}, got_oe & mask,
               f.oe & mask);
         frames_seen++;
         rise_cnt = 0;
      end
   end

   // PHY responder: drives turnaround bit 2 and data after MDC falls
   always @(negedge mdc) begin : phy
      int t;
      t = phy_len - rise_cnt;
      if (phy_read && rise_cnt > 0 && t >= 1 && t <= 17) begin
         phy_oe = 1'b1;
         phy_o  = phy_resp[t-1];
      end else begin
         phy_oe = 1'b0;
      end
   end

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] d;
      do rd(ADDR_WDAT, d); while (d[31]);
   endtask

   task automatic run_frame(input bit c45, input bit pre, input logic [1:0] op,
                            input logic [4:0] phy_a, input logic [4:0] dev,
                            input logic [15:0] wd, input logic [15:0] resp,
                            input bit ta_bad, input int div, input bit measure,
                            input bit probe, input bit intrude, input string req);
      frame_t      f;
      logic [1:0]  st, wop;
      bit          rdop;
      logic [31:0] tail, d, d2;
      realtime     t0, t1;
      rdop = c45 ? op[1] : op[0];
      st   = c45 ? 2'b00 : 2'b01;
      wop  = c45 ? op : (op[0] ? 2'b10 : 2'b01);
      tail = rdop ? {st, wop, phy_a, dev, 1'b1, ta_bad, resp}
                  : {st, wop, phy_a, dev, 2'b10, wd};
      f.len  = pre ? 64 : 32;
      f.bits = pre ? {32'hFFFF_FFFF, tail} : {32'h0, tail};
      f.oe   = rdop ? ~64'h3FFFF : '1;
      f.req  = req;
      wr(ADDR_CLK, {22'b0, pre, c45, 8'(div)});
      wr(ADDR_WDAT, {16'h0, wd});
      phy_len  = f.len;
      phy_read = rdop;
      phy_resp = {ta_bad, resp};
      exp_q.push_back(f);
      frames_sent++;
      wr(ADDR_CMD, {11'b0, dev, 3'b0, phy_a, 6'b0, op});
      if (measure) begin
         @(posedge mdc); t0 = $realtime;
         @(posedge mdc); t1 = $realtime;
         check(int'((t1 - t0) / 5.0) == 2 * (div + 1), "R2 MDC period",
               64'(int'((t1 - t0) / 5.0)), 64'(2 * (div + 1)));
      end
      if (probe) begin
         repeat (4) @(negedge clk);
         rd(ADDR_WDAT, d);
         rd(ADDR_RDAT, d2);
         check(d[31] && d2[31], "R8 pending during frame", {d[31], d2[31]}, 2'b11);
      end
      if (intrude) begin
         repeat (6) @(negedge clk);
         wr(ADDR_CMD, {11'b0, 5'h1E, 3'b0, 5'h07, 6'b0, 2'b01});
      end
      wait_idle();
      rd(ADDR_RDAT, d);
      check(!d[31], "R8 pending clears", 64'(d[31]), 64'd0);
      check(!mdc && !mdio_oe && mdio_o, "R10 idle after frame",
            {mdc, mdio_oe, mdio_o}, 3'b001);
      if (rdop) begin
         check(d[30] == !ta_bad, "R7 valid flag", 64'(d[30]), 64'(!ta_bad));
         if (!ta_bad) check(d[15:0] == resp, "R7 read data", 64'(d[15:0]), 64'(resp));
      end else begin
         check(!d[30], "R7 valid stays clear on non-read", 64'(d[30]), 64'd0);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] d;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(ADDR_CLK, d);
      check(d == 32'h204, "R1 clock/mode reset", 64'(d), 64'h204);
      check(!mdc && !mdio_oe, "R1 bus idle", {mdc, mdio_oe}, 2'b00);
      rd(ADDR_RDAT, d);
      check(d[31:30] == 2'b00, "R1 flags clear", 64'(d[31:30]), 64'd0);
      repeat (20) @(negedge clk);
      check(!mdc, "R2 MDC static while idle", 64'(mdc), 64'd0);

      // R4 clause-22 write with preamble, R3 bit timing, R8 pending
      run_frame(1'b0, 1'b1, 2'd0, 5'h05, 5'h11, 16'hA5C3, 16'h0, 1'b0, 2, 1'b1, 1'b1,
                1'b0, "R4 R3 c22 write frame");
      // R4/R7 clause-22 read, valid
      run_frame(1'b0, 1'b1, 2'd1, 5'h1F, 5'h02, 16'h0, 16'h1234, 1'b0, 3, 1'b1, 1'b0,
                1'b0, "R4 R7 c22 read frame");
      // R7 bad turnaround
      run_frame(1'b0, 1'b1, 2'd1, 5'h03, 5'h01, 16'h0, 16'h5555, 1'b1, 2, 1'b0, 1'b0,
                1'b0, "R7 c22 read bad turnaround");
      // R5 no preamble
      run_frame(1'b0, 1'b0, 2'd0, 5'h0A, 5'h1C, 16'h0F0F, 16'h0, 1'b0, 2, 1'b0, 1'b0,
                1'b0, "R5 c22 write without preamble");
      run_frame(1'b0, 1'b0, 2'd1, 5'h11, 5'h04, 16'h0, 16'h8001, 1'b0, 2, 1'b0, 1'b0,
                1'b0, "R5 c22 read without preamble");
      // R6 clause-45 cycles
      run_frame(1'b1, 1'b1, 2'd0, 5'h02, 5'h03, 16'h0008, 16'h0, 1'b0, 2, 1'b0, 1'b0,
                1'b0, "R6 c45 address cycle");
      run_frame(1'b1, 1'b1, 2'd1, 5'h02, 5'h03, 16'hC0DE, 16'h0, 1'b0, 2, 1'b0, 1'b0,
                1'b0, "R6 c45 write cycle");
      run_frame(1'b1, 1'b1, 2'd3, 5'h02, 5'h1E, 16'h0, 16'hBEEF, 1'b0, 2, 1'b0, 1'b0,
                1'b0, "R6 R7 c45 read cycle");
      run_frame(1'b1, 1'b0, 2'd2, 5'h1D, 5'h01, 16'h0, 16'h0F0F, 1'b0, 2, 1'b0, 1'b0,
                1'b0, "R6 R7 c45 read post-increment");
      // R9 command during pending ignored
      run_frame(1'b0, 1'b1, 2'd0, 5'h09, 5'h09, 16'h1357, 16'h0, 1'b0, 2, 1'b0, 1'b1,
                1'b1, "R9 frame unchanged by second command");
      repeat (400) @(negedge clk);
      check(frames_seen == frames_sent, "R9 frame count", 64'(frames_seen),
            64'(frames_sent));
      check(exp_q.size() == 0, "R9 no outstanding frame", 64'(exp_q.size()), 64'd0);
      check(!mdc && !mdio_oe, "R10 final idle", {mdc, mdio_oe}, 2'b00);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule